// File: doc/BRIEF.md
# CEC Controller Register Front End

This block is the software-facing side of a CEC bus controller. It sits between a 32-bit word-addressed register bus and a protocol engine that handles the bit timing. Software loads a message of up to sixteen bytes into a transmit buffer, four bytes to a little-endian word. It writes the length minus one and sets a start bit. The block then streams the bytes to the engine over a valid/ready byte interface, marking the final byte. The engine reports the outcome with single-cycle pulses: done, no-acknowledge, line error or arbitration lost.

Received bytes arrive from the engine on a second byte stream with an end-of-message flag. The first complete message is captured and the receive buffer locks. The buffer stays locked until software writes the release register. A message that starts while the buffer is locked is thrown away whole, and an overrun status bit is raised in place of end-of-message. The receive stream never applies back-pressure: `rx_ready` is always high, and each accepted byte is either stored or discarded. On the transmit stream the engine may hold `tx_ready` low for any number of cycles. While it does, the offered byte and last flag stay put.

A 16-bit logical-address mask is kept. Bit 15 is the broadcast address and is set whenever any address is claimed. An acknowledge-match output tells the engine that a frame addressed to a claimed address should be acknowledged automatically. Six sticky status bits feed a level interrupt through an active-high mask. Software clears them by writing ones.

Top module: `cec_regif`

Register word addresses: 0x00 control (bit 0 global enable, bit 1 auto-acknowledge), 0x01 address mask, 0x02 transmit length minus one, 0x03 start, 0x04 status, 0x05 interrupt mask, 0x06 status clear, 0x07 receive status, 0x08 receive release, 0x10–0x13 transmit words, 0x18–0x1B receive words. Status bits: 0 done, 1 NACK, 2 line error, 3 arbitration lost, 4 receive end-of-message, 5 receive overrun.

## Requirements
- R1: After reset, status, interrupt mask, receive status and `irq` read 0, `tx_valid` is 0 and the receive buffer is unlocked.
- R2: After a start, bytes 0..N are offered on `tx_byte` in order, where N is the value in the length register (0x02). Byte i comes from transmit word i/4, bits 8*(i mod 4)+7 to 8*(i mod 4). `tx_last` is high on byte N only, and `tx_valid` falls after that byte is taken.
- R3: While `tx_valid` is high and `tx_ready` is low, `tx_byte`, `tx_last` and `tx_valid` hold their values.
- R4: Writing 1 to bit 0 of the start register (0x03) begins a transfer only when the block is enabled and no transfer is outstanding. A transfer stays outstanding until an outcome pulse arrives.
- R5: Outcome pulses set their status bits: done sets bit 0, NACK bit 1, line error bit 2 and arbitration lost bit 3. Any of them ends the outstanding transfer.
- R6: `irq` is high exactly when some status bit and the same interrupt-mask bit are both 1.
- R7: Writing a value to the clear register (0x06) clears only the status bits that are 1 in it; all ones clears every bit. An event in the same cycle still sets its bit.
- R8: When a message ends, the receive status register (0x07) shows the length minus one in bits 3:0 and 1 in bit 7. Status bit 4 is set, and the bytes read back from receive words 0x18 onward in the R2 packing.
- R9: A message that begins while the buffer is locked leaves the receive status and data unchanged and does not set bit 4. Status bit 5 is set instead.
- R10: Writing 1 to the release register (0x08) clears bit 7 of receive status, and the next message is captured.
- R11: Writing a nonzero value to the address register (0x01) stores it with bit 15 forced to 1; writing 0 stores 0.
- R12: `ack_match` is 1 exactly when global enable and auto-acknowledge are both set and the address-mask bit selected by `rx_dest` is 1.
- R13: With global enable clear, a start write is ignored and received bytes are discarded without any status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Engine takes the byte |
| tx_byte | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the message |
| ev_done | input | 1 | Transfer completed pulse |
| ev_nack | input | 1 | Transfer not acknowledged pulse |
| ev_line_err | input | 1 | Line error pulse |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Always 1 |
| rx_byte | input | 8 | Received byte |
| rx_last | input | 1 | End of received message |
| rx_dest | input | 4 | Destination address of the incoming frame |
| ack_match | output | 1 | Frame should be acknowledged |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume single-cycle outcome pulses, and they assume software does not write release in the same cycle the engine delivers a final byte. Under those assumptions, a locked buffer keeps its length until released, and a stalled transmit byte holds still. The stimulus keeps to these rules: it sends each outcome pulse alone and only after the stream has ended. It leaves a full idle cycle between a release write and the next received message. The only case that puts a clear write and an event in the same cycle is the one that checks which of the two wins.

// File: rtl/cec_regif_pkg.sv
package cec_regif_pkg;
  localparam int AW    = 5;
  localparam int DW    = 32;
  localparam int IRQ_N = 6;

  localparam logic [AW-1:0] A_CTRL   = 5'h00;
  localparam logic [AW-1:0] A_ADDR   = 5'h01;
  localparam logic [AW-1:0] A_TXLEN  = 5'h02;
  localparam logic [AW-1:0] A_TXGO   = 5'h03;
  localparam logic [AW-1:0] A_ISTAT  = 5'h04;
  localparam logic [AW-1:0] A_IMASK  = 5'h05;
  localparam logic [AW-1:0] A_ICLR   = 5'h06;
  localparam logic [AW-1:0] A_RXSTAT = 5'h07;
  localparam logic [AW-1:0] A_RXREL  = 5'h08;
  localparam logic [AW-1:0] A_TXBUF  = 5'h10;
  localparam logic [AW-1:0] A_RXBUF  = 5'h18;

  localparam int SB_DONE = 0;
  localparam int SB_NACK = 1;
  localparam int SB_LERR = 2;
  localparam int SB_ARB  = 3;
  localparam int SB_EOM  = 4;
  localparam int SB_OVR  = 5;
endpackage

// File: rtl/cec_tx_path.sv
module cec_tx_path #(
  parameter int MSG_BYTES = 16,
  parameter int LEN_W     = $clog2(MSG_BYTES),
  parameter int WIDX_W    = LEN_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] wr_word,
  input  logic [31:0]       wr_data,
  input  logic              len_we,
  input  logic [LEN_W-1:0]  len_d,
  input  logic              go_i,
  input  logic              en_i,
  input  logic              outcome_i,
  input  logic [WIDX_W-1:0] rd_word,
  output logic [31:0]       rd_data,
  output logic [LEN_W-1:0]  len_q,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_byte,
  output logic              tx_last
);
  logic [7:0]       buf_q [MSG_BYTES];
  logic [LEN_W-1:0] idx_q;
  logic             busy_q, stream_q;
  logic             start;

  assign start = go_i & en_i & ~busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MSG_BYTES; i++) buf_q[i] <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < 4; b++)
        buf_q[{wr_word, b[1:0]}] <= wr_data[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q    <= '0;
      idx_q    <= '0;
      busy_q   <= 1'b0;
      stream_q <= 1'b0;
    end else begin
      if (len_we) len_q <= len_d;
      if (start) begin
        busy_q   <= 1'b1;
        stream_q <= 1'b1;
        idx_q    <= '0;
      end else if (stream_q && tx_ready) begin
        if (idx_q == len_q) stream_q <= 1'b0;
        else                idx_q    <= idx_q + 1'b1;
      end
      if (outcome_i && busy_q && !start) begin
        busy_q   <= 1'b0;
        stream_q <= 1'b0;
      end
    end
  end

  assign tx_valid = stream_q;
  assign tx_byte  = buf_q[idx_q];
  assign tx_last  = stream_q & (idx_q == len_q);

  for (genvar b = 0; b < 4; b++) begin : g_rd
    assign rd_data[8*b +: 8] = buf_q[{rd_word, 2'(b)}];
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !outcome_i) |=> (tx_valid && $stable(tx_byte) && $stable(tx_last)));

  assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stream_q) |-> $past(go_i && en_i));
endmodule

// File: rtl/cec_rx_path.sv
module cec_rx_path #(
  parameter int MSG_BYTES = 16,
  parameter int LEN_W     = $clog2(MSG_BYTES),
  parameter int WIDX_W    = LEN_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              byte_valid,
  input  logic [7:0]        byte_i,
  input  logic              last_i,
  input  logic              release_i,
  input  logic [WIDX_W-1:0] rd_word,
  output logic [31:0]       rd_data,
  output logic [LEN_W-1:0]  len_q,
  output logic              locked_q,
  output logic              eom_o,
  output logic              ovr_o
);
  localparam logic [LEN_W:0] FULL = (LEN_W+1)'(MSG_BYTES);

  logic [7:0]     buf_q [MSG_BYTES];
  logic [LEN_W:0] wptr_q;
  logic           in_msg_q, drop_q;
  logic           take, drop_now, store;

  assign take     = en_i & byte_valid;
  assign drop_now = in_msg_q ? drop_q : locked_q;
  assign store    = take & ~drop_now & (wptr_q < FULL);
  assign eom_o    = take & last_i & ~drop_now;
  assign ovr_o    = take & last_i & drop_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MSG_BYTES; i++) buf_q[i] <= '0;
    end else if (store) begin
      buf_q[wptr_q[LEN_W-1:0]] <= byte_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q   <= '0;
      in_msg_q <= 1'b0;
      drop_q   <= 1'b0;
      locked_q <= 1'b0;
      len_q    <= '0;
    end else begin
      if (release_i) locked_q <= 1'b0;
      if (take) begin
        if (last_i) begin
          in_msg_q <= 1'b0;
          drop_q   <= 1'b0;
          wptr_q   <= '0;
          if (!drop_now) begin
            locked_q <= 1'b1;
            len_q    <= (wptr_q < FULL) ? wptr_q[LEN_W-1:0] : {LEN_W{1'b1}};
          end
        end else begin
          in_msg_q <= 1'b1;
          drop_q   <= drop_now;
          if (store) wptr_q <= wptr_q + 1'b1;
        end
      end
    end
  end

  for (genvar b = 0; b < 4; b++) begin : g_rd
    assign rd_data[8*b +: 8] = buf_q[{rd_word, 2'(b)}];
  end

  assert_locks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eom_o |=> locked_q);

  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !release_i) |=> (locked_q && $stable(len_q)));

  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && !eom_o) |=> !locked_q);
endmodule

// File: rtl/cec_irq_ctrl.sv
module cec_irq_ctrl #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_i,
  input  logic         clr_we,
  input  logic [N-1:0] clr_d,
  input  logic         mask_we,
  input  logic [N-1:0] mask_d,
  output logic [N-1:0] stat_q,
  output logic [N-1:0] mask_q,
  output logic         irq_o
);
  logic [N-1:0] clr_bits;
  assign clr_bits = clr_we ? clr_d : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_bits) | ev_i;
      if (mask_we) mask_q <= mask_d;
    end
  end

  assign irq_o = |(stat_q & mask_q);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_i) |=> ((stat_q & $past(ev_i)) == $past(ev_i)));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_masked_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);
endmodule

// File: rtl/cec_regif.sv
module cec_regif
  import cec_regif_pkg::*;
#(
  parameter int MSG_BYTES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          bus_rvalid,
  output logic [DW-1:0] bus_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_byte,
  output logic          tx_last,
  input  logic          ev_done,
  input  logic          ev_nack,
  input  logic          ev_line_err,
  input  logic          ev_arb_lost,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_byte,
  input  logic          rx_last,
  input  logic [3:0]    rx_dest,
  output logic          ack_match,
  output logic          irq
);
  localparam int LEN_W  = $clog2(MSG_BYTES);
  localparam int WORDS  = MSG_BYTES / 4;
  localparam int WIDX_W = $clog2(WORDS);

  logic wr, rd, hit_tx, hit_rx;
  logic en_q, autoack_q;
  logic [15:0] addr_q;
  logic [WIDX_W-1:0] widx;
  logic [31:0] tx_rd, rx_rd, rd_mux;
  logic [LEN_W-1:0] tx_len, rx_len;
  logic rx_locked, rx_eom, rx_ovr;
  logic [IRQ_N-1:0] stat, mask, events;

  assign wr     = bus_valid & bus_write;
  assign rd     = bus_valid & ~bus_write;
  assign hit_tx = (bus_addr >= A_TXBUF) && (bus_addr < A_TXBUF + AW'(WORDS));
  assign hit_rx = (bus_addr >= A_RXBUF) && (bus_addr < A_RXBUF + AW'(WORDS));
  assign widx   = bus_addr[WIDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      autoack_q <= 1'b0;
      addr_q    <= '0;
    end else if (wr) begin
      if (bus_addr == A_CTRL) begin
        en_q      <= bus_wdata[0];
        autoack_q <= bus_wdata[1];
      end
      if (bus_addr == A_ADDR)
        addr_q <= (bus_wdata[15:0] == '0) ? '0 : (bus_wdata[15:0] | 16'h8000);
    end
  end

  cec_tx_path #(.MSG_BYTES(MSG_BYTES), .LEN_W(LEN_W), .WIDX_W(WIDX_W)) u_tx (
    .clk, .rst_n,
    .wr_en    (wr & hit_tx),
    .wr_word  (widx),
    .wr_data  (bus_wdata),
    .len_we   (wr && bus_addr == A_TXLEN),
    .len_d    (bus_wdata[LEN_W-1:0]),
    .go_i     (wr && bus_addr == A_TXGO && bus_wdata[0]),
    .en_i     (en_q),
    .outcome_i(ev_done | ev_nack | ev_line_err | ev_arb_lost),
    .rd_word  (widx),
    .rd_data  (tx_rd),
    .len_q    (tx_len),
    .tx_valid, .tx_ready, .tx_byte, .tx_last
  );

  cec_rx_path #(.MSG_BYTES(MSG_BYTES), .LEN_W(LEN_W), .WIDX_W(WIDX_W)) u_rx (
    .clk, .rst_n,
    .en_i      (en_q),
    .byte_valid(rx_valid),
    .byte_i    (rx_byte),
    .last_i    (rx_last),
    .release_i (wr && bus_addr == A_RXREL && bus_wdata[0]),
    .rd_word   (widx),
    .rd_data   (rx_rd),
    .len_q     (rx_len),
    .locked_q  (rx_locked),
    .eom_o     (rx_eom),
    .ovr_o     (rx_ovr)
  );

  always_comb begin
    events = '0;
    events[SB_DONE] = ev_done;
    events[SB_NACK] = ev_nack;
    events[SB_LERR] = ev_line_err;
    events[SB_ARB]  = ev_arb_lost;
    events[SB_EOM]  = rx_eom;
    events[SB_OVR]  = rx_ovr;
  end

  cec_irq_ctrl #(.N(IRQ_N)) u_irq (
    .clk, .rst_n,
    .ev_i   (events),
    .clr_we (wr && bus_addr == A_ICLR),
    .clr_d  (bus_wdata[IRQ_N-1:0]),
    .mask_we(wr && bus_addr == A_IMASK),
    .mask_d (bus_wdata[IRQ_N-1:0]),
    .stat_q (stat),
    .mask_q (mask),
    .irq_o  (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_tx)      rd_mux = tx_rd;
    else if (hit_rx) rd_mux = rx_rd;
    else begin
      case (bus_addr)
        A_CTRL:   rd_mux = {30'd0, autoack_q, en_q};
        A_ADDR:   rd_mux = {16'd0, addr_q};
        A_TXLEN:  rd_mux = 32'(tx_len);
        A_ISTAT:  rd_mux = 32'(stat);
        A_IMASK:  rd_mux = 32'(mask);
        A_RXSTAT: rd_mux = {24'd0, rx_locked, 7'(rx_len)};
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_mux;
    end
  end

  assign rx_ready  = 1'b1;
  assign ack_match = en_q & autoack_q & addr_q[rx_dest];

  assert_bcast_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|addr_q) |-> addr_q[15]);

  assert_ack_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q || !autoack_q) |-> !ack_match);

  assert_rvalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> bus_rvalid);
endmodule

// File: tb/tb_cec_regif.sv
`timescale 1ns/1ps
module tb_cec_regif;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 0, bus_write = 0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_rvalid;
  logic [31:0] bus_rdata;
  logic tx_valid, tx_last, rx_ready, ack_match, irq;
  logic tx_ready = 0;
  logic [7:0] tx_byte;
  logic ev_done = 0, ev_nack = 0, ev_line_err = 0, ev_arb_lost = 0;
  logic rx_valid = 0, rx_last = 0;
  logic [7:0] rx_byte = '0;
  logic [3:0] rx_dest = '0;

  int checks = 0, errors = 0;
  bit running = 0;
  logic [7:0] exp_tx [$];
  logic [31:0] rdv;

  always #2.5 clk = ~clk;

  cec_regif dut (.*);

  // behavioural reference for status / mask / lock
  logic [5:0] m_stat = 0, m_mask = 0;
  bit m_en = 0, m_locked = 0, m_inmsg = 0, m_drop = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = 0; m_mask = 0; m_en = 0; m_locked = 0; m_inmsg = 0; m_drop = 0;
    end else begin
      bit dn, eom, ovr, nl;
      eom = 0; ovr = 0;
      nl = m_locked;
      if (m_en && rx_valid) begin
        dn = m_inmsg ? m_drop : m_locked;
        if (rx_last) begin
          m_inmsg = 0;
          if (dn) ovr = 1; else eom = 1;
        end else begin
          m_inmsg = 1; m_drop = dn;
        end
      end
      if (bus_valid && bus_write && bus_addr == 5'h08 && bus_wdata[0]) nl = 0;
      if (eom) nl = 1;
      m_locked = nl;
      if (bus_valid && bus_write && bus_addr == 5'h06) m_stat = m_stat & ~bus_wdata[5:0];
      if (bus_valid && bus_write && bus_addr == 5'h05) m_mask = bus_wdata[5:0];
      if (bus_valid && bus_write && bus_addr == 5'h00) m_en = bus_wdata[0];
      m_stat = m_stat | {ovr, eom, ev_arb_lost, ev_line_err, ev_nack, ev_done};
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && running) chk("R6 irq vs model", irq, |(m_stat & m_mask));

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk); bus_valid = 0; d = bus_rdata;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which) 0: ev_done = 1; 1: ev_nack = 1; 2: ev_line_err = 1; default: ev_arb_lost = 1; endcase
    @(negedge clk); ev_done = 0; ev_nack = 0; ev_line_err = 0; ev_arb_lost = 0;
  endtask

  task automatic rx_send(input logic [7:0] b [$]);
    foreach (b[i]) begin
      @(negedge clk); rx_valid = 1; rx_byte = b[i]; rx_last = (i == b.size() - 1);
    end
    @(negedge clk); rx_valid = 0; rx_last = 0;
  endtask

  task automatic load_tx();
    for (int w = 0; w < (exp_tx.size() + 3) / 4; w++) begin
      logic [31:0] word = '0;
      for (int k = 0; k < 4; k++)
        if (w * 4 + k < exp_tx.size()) word[8*k +: 8] = exp_tx[w*4+k];
      wr(5'h10 + 5'(w), word);
    end
    wr(5'h02, 32'(exp_tx.size() - 1));
    wr(5'h03, 32'h1);
  endtask

  task automatic tx_collect(input bit bp);
    int pos = 0; int guard = 0; bit fin = 0; bit stalled = 0; logic [7:0] held = 0;
    while (!fin && guard < 200) begin
      @(negedge clk); guard++;
      if (stalled) begin
        chk("R3 valid held", tx_valid, 1'b1);
        chk("R3 byte held", tx_byte, held);
        stalled = 0;
      end
      tx_ready = bp ? guard[0] : 1'b1;
      if (tx_valid) begin
        if (tx_ready) begin
          chk("R2 byte", tx_byte, exp_tx[pos]);
          chk("R2 last", tx_last, pos == exp_tx.size() - 1);
          if (tx_last) fin = 1;
          pos++;
        end else begin
          held = tx_byte; stalled = 1;
        end
      end
    end
    @(negedge clk); tx_ready = 0;
    chk("R2 valid falls", tx_valid, 1'b0);
    chk("R2 byte count", pos, exp_tx.size());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    running = 1;
    // R1 reset state
    rd(5'h04, rdv); chk("R1 status", rdv, 0);
    rd(5'h05, rdv); chk("R1 mask", rdv, 0);
    rd(5'h07, rdv); chk("R1 rx status", rdv, 0);
    chk("R1 irq", irq, 0);
    chk("R1 tx_valid", tx_valid, 0);

    wr(5'h00, 32'h3);
    wr(5'h05, 32'h37);

    // R2 five-byte message, no stalls
    exp_tx = '{8'h10, 8'h11, 8'h12, 8'h13, 8'h14};
    load_tx();
    tx_collect(0);
    // R4 start while outstanding is ignored
    wr(5'h03, 32'h1);
    @(negedge clk); chk("R4 no restart while busy", tx_valid, 0);
    pulse(0);
    rd(5'h04, rdv); chk("R5 done bit", rdv, 32'h01); chk("R5 model", rdv, 32'(m_stat));
    chk("R6 irq raised", irq, 1);

    // R3 sixteen bytes with back-pressure
    exp_tx = {};
    for (int i = 0; i < 16; i++) exp_tx.push_back(8'(i * 7 + 3));
    load_tx();
    tx_collect(1);
    pulse(1);
    rd(5'h04, rdv); chk("R5 nack bit", rdv, 32'h03);
    pulse(2);
    pulse(3);
    rd(5'h04, rdv); chk("R5 err and arb bits", rdv, 32'h0F);

    // R7 partial clear, R6 mask gating
    wr(5'h06, 32'h07);
    rd(5'h04, rdv); chk("R7 partial clear", rdv, 32'h08);
    chk("R6 masked arb bit", irq, 0);
    wr(5'h05, 32'h3F);
    chk("R6 unmasked arb bit", irq, 1);
    wr(5'h06, 32'hFFFF_FFFF);
    rd(5'h04, rdv); chk("R7 clear all", rdv, 0);
    // R7 event wins over clear in the same cycle
    @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = 5'h06; bus_wdata = 32'h1; ev_done = 1;
    @(negedge clk); bus_valid = 0; bus_write = 0; ev_done = 0;
    rd(5'h04, rdv); chk("R7 set wins", rdv, 32'h01);
    wr(5'h06, 32'hFFFF_FFFF);

    // R8 capture
    rx_send('{8'hA0, 8'hA1, 8'hA2});
    rd(5'h07, rdv); chk("R8 rx status", rdv, 32'h82);
    rd(5'h18, rdv); chk("R8 rx word0", rdv, 32'h00A2A1A0);
    rd(5'h04, rdv); chk("R8 eom bit", rdv, 32'h10);
    wr(5'h06, 32'h3F);

    // R9 discard while locked
    rx_send('{8'hB0, 8'hB1});
    rd(5'h07, rdv); chk("R9 rx status kept", rdv, 32'h82);
    rd(5'h18, rdv); chk("R9 rx word0 kept", rdv, 32'h00A2A1A0);
    rd(5'h04, rdv); chk("R9 overrun not eom", rdv, 32'h20);
    wr(5'h06, 32'h3F);

    // R10 release
    wr(5'h08, 32'h1);
    rd(5'h07, rdv); chk("R10 unlocked", rdv, 32'h02);
    rx_send('{8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5});
    rd(5'h07, rdv); chk("R10 new status", rdv, 32'h85);
    rd(5'h18, rdv); chk("R10 word0", rdv, 32'hC3C2C1C0);
    rd(5'h19, rdv); chk("R10 word1", rdv, 32'h0000C5C4);
    wr(5'h06, 32'h3F);

    // R11 address mask
    wr(5'h01, 32'h0004);
    rd(5'h01, rdv); chk("R11 broadcast forced", rdv, 32'h8004);
    wr(5'h01, 32'h0);
    rd(5'h01, rdv); chk("R11 cleared", rdv, 0);
    wr(5'h01, 32'h0004);

    // R12 acknowledge match
    @(negedge clk); rx_dest = 4'd2;
    @(negedge clk); chk("R12 match", ack_match, 1);
    rx_dest = 4'd3;
    @(negedge clk); chk("R12 no match", ack_match, 0);
    rx_dest = 4'd15;
    @(negedge clk); chk("R12 broadcast", ack_match, 1);
    wr(5'h00, 32'h1);
    chk("R12 auto-ack off", ack_match, 0);

    // R13 disabled
    wr(5'h08, 32'h1);
    wr(5'h00, 32'h0);
    wr(5'h02, 32'h0);
    wr(5'h03, 32'h1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R13 no start", tx_valid, 0);
    end
    rx_send('{8'hD0});
    rd(5'h04, rdv); chk("R13 no status", rdv, 0);
    rd(5'h07, rdv); chk("R13 rx untouched", rdv, 32'h05);

    running = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule